// File: doc/BRIEF.md
# Rollback History Buffer

This block tracks instructions in program order so that execution units may finish them out of order while exceptions stay precise. Each dispatched instruction, branches included, takes one slot in a circular buffer. The slot records whether the instruction writes an architectural register, which register it writes, and the value that register held before the write. Execution units report completion by tag, with a flag that marks an exception.

The oldest slot leaves the buffer once it has finished cleanly. If the oldest slot finished with an exception, or an interrupt is pending, the block stops allocating and requests a flush of the instruction queue. It then walks back from the youngest slot, one slot per cycle. Each step sends the saved old value to the register file through a restore port. When the buffer is empty it pulses a done signal and goes back to normal operation.

Top module: `hist_buf`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready` is 1, `alloc_tag` is 0, and `retire_valid`, `iq_flush`, `rst_wr_en`, `recov_active` and `recov_done` are all 0.
- R2: Accepted allocations receive tags that count up by one from 0 and wrap modulo DEPTH. The tag is the slot number, with default DEPTH 8 and 3-bit tags.
- R3: With DEPTH entries held, `alloc_ready` is 0 and an offered allocation is dropped, so no slot's saved contents change.
- R4: `retire_valid` with `retire_tag` marks the oldest entry leaving the buffer. This happens only once that entry has completed without an exception, whatever the state of younger entries.
- R5: At most one entry retires per cycle. Retirement never overlaps a flush request or a rollback.
- R6: When the oldest entry has completed with an exception, it does not retire. `iq_flush` is high for exactly that one cycle, allocation is refused, and rollback starts on the next cycle.
- R7: During rollback, one entry per cycle is removed, youngest first, down to and including the oldest. For an entry whose destination-valid bit was set, `rst_wr_en` is 1 and `rst_wr_idx`/`rst_wr_data` carry its saved register index and old value. For any other entry, `rst_wr_en` stays 0.
- R8: The cycle after the last entry is removed, `recov_done` is high for one cycle and the buffer is empty. The next allocation gets the tag of the slot that was oldest when rollback began.
- R9: A one-cycle pulse on `irq_req` is remembered. While the oldest entry has completed cleanly, it still retires first. As soon as the oldest entry is not complete, `iq_flush` rises and all remaining entries are rolled back as in R7.
- R10: During rollback `alloc_ready` is 0, and offered allocations are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Dispatch offers a new instruction |
| alloc_dest_vld | input | 1 | The instruction writes an architectural register |
| alloc_dest_idx | input | 5 | Index of the destination register |
| alloc_old_val | input | 32 | Value the destination held before this instruction |
| alloc_ready | output | 1 | Allocation accepted this cycle if offered |
| alloc_tag | output | 3 | Tag given to the offered instruction |
| cmpl_valid | input | 1 | An execution unit reports a finished instruction |
| cmpl_tag | input | 3 | Tag of the finished instruction |
| cmpl_exc | input | 1 | The finished instruction raised an exception |
| irq_req | input | 1 | Interrupt request pulse |
| retire_valid | output | 1 | The oldest entry retires this cycle |
| retire_tag | output | 3 | Tag of the retiring entry |
| rst_wr_en | output | 1 | Restore write to the register file |
| rst_wr_idx | output | 5 | Register index of the restore write |
| rst_wr_data | output | 32 | Saved old value being restored |
| iq_flush | output | 1 | Instruction queue flush request |
| recov_active | output | 1 | Rollback in progress |
| recov_done | output | 1 | One-cycle pulse when rollback has emptied the buffer |

## Verification
First the buffer is filled to capacity from a vector table that mixes entries with and without a destination. This exposes tag counting, wrap-around and the full stall. Completions are then given in an order that differs from allocation order, which separates in-order retirement from retirement on completion. An exception on the oldest of a wrapped set of entries checks that the restore stream runs youngest-first across the wrap. It also checks that entries without a destination stay silent, and that dropped allocations during the full and rollback periods left no trace. A final interrupt pulse that arrives while the head is complete tells retire-first apart from immediate rollback.

// File: rtl/hb_pkg.sv
package hb_pkg;

  typedef enum logic [0:0] {
    HB_RUN      = 1'b0,
    HB_ROLLBACK = 1'b1
  } hb_state_e;

endpackage

// File: rtl/hb_ptrs.sv
module hb_ptrs #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             unpush,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic [PTR_W-1:0] young,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] head_q, head_d;
  logic [PTR_W-1:0] tail_q, tail_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ptr_en;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
    return (p == '0) ? LAST_PTR : p - 1'b1;
  endfunction

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    if (pop) begin
      head_d = ptr_inc(head_q);
    end
    if (push) begin
      tail_d = ptr_inc(tail_q);
    end else if (unpush) begin
      tail_d = ptr_dec(tail_q);
    end
    if (push && !pop) begin
      cnt_d = cnt_q + 1'b1;
    end else if (pop && !push) begin
      cnt_d = cnt_q - 1'b1;
    end else if (unpush) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  assign ptr_en = push | pop | unpush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (ptr_en) begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  assign head  = head_q;
  assign tail  = tail_q;
  assign young = ptr_dec(tail_q);
  assign count = cnt_q;
  assign full  = (cnt_q == FULL_CNT);
  assign empty = (cnt_q == '0);

endmodule

// File: rtl/hb_store.sv
module hb_store #(
  parameter int DEPTH  = 8,
  parameter int RIDX_W = 5,
  parameter int DATA_W = 32,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_slot,
  input  logic              wr_dvld,
  input  logic [RIDX_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_old,
  input  logic              pop_en,
  input  logic [PTR_W-1:0]  pop_slot,
  input  logic              undo_en,
  input  logic [PTR_W-1:0]  undo_slot,
  input  logic              cmpl_en,
  input  logic [PTR_W-1:0]  cmpl_slot,
  input  logic              cmpl_exc,
  input  logic [PTR_W-1:0]  head_slot,
  input  logic [PTR_W-1:0]  young_slot,
  output logic              head_done,
  output logic              head_exc,
  output logic              young_dvld,
  output logic [RIDX_W-1:0] young_idx,
  output logic [DATA_W-1:0] young_old
);

  logic [DEPTH-1:0]  slot_done;
  logic [DEPTH-1:0]  slot_exc;
  logic [DEPTH-1:0]  slot_dvld;
  logic [RIDX_W-1:0] slot_idx [DEPTH];
  logic [DATA_W-1:0] slot_old [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic              live_q, live_d;
    logic              done_q, done_d;
    logic              exc_q,  exc_d;
    logic              flag_en;
    logic              dvld_q;
    logic [RIDX_W-1:0] idx_q;
    logic [DATA_W-1:0] old_q;
    logic              wr_hit, pop_hit, undo_hit, cmpl_hit;

    assign wr_hit   = wr_en   && (wr_slot   == PTR_W'(s));
    assign pop_hit  = pop_en  && (pop_slot  == PTR_W'(s));
    assign undo_hit = undo_en && (undo_slot == PTR_W'(s));
    assign cmpl_hit = cmpl_en && (cmpl_slot == PTR_W'(s)) && live_q;

    always_comb begin
      live_d = live_q;
      done_d = done_q;
      exc_d  = exc_q;
      if (wr_hit) begin
        live_d = 1'b1;
        done_d = 1'b0;
        exc_d  = 1'b0;
      end else if (pop_hit || undo_hit) begin
        live_d = 1'b0;
        done_d = 1'b0;
        exc_d  = 1'b0;
      end else if (cmpl_hit) begin
        done_d = 1'b1;
        exc_d  = cmpl_exc;
      end
    end

    assign flag_en = wr_hit | pop_hit | undo_hit | cmpl_hit;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        live_q <= 1'b0;
        done_q <= 1'b0;
        exc_q  <= 1'b0;
      end else if (flag_en) begin
        live_q <= live_d;
        done_q <= done_d;
        exc_q  <= exc_d;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_hit) begin
        dvld_q <= wr_dvld;
        idx_q  <= wr_idx;
        old_q  <= wr_old;
      end
    end

    assign slot_done[s] = done_q;
    assign slot_exc[s]  = exc_q;
    assign slot_dvld[s] = dvld_q;
    assign slot_idx[s]  = idx_q;
    assign slot_old[s]  = old_q;
  end

  assign head_done  = slot_done[head_slot];
  assign head_exc   = slot_exc[head_slot];
  assign young_dvld = slot_dvld[young_slot];
  assign young_idx  = slot_idx[young_slot];
  assign young_old  = slot_old[young_slot];

endmodule

// File: rtl/hb_ctrl.sv
module hb_ctrl
  import hb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic empty,
  input  logic full,
  input  logic head_done,
  input  logic head_exc,
  input  logic young_dvld,
  input  logic alloc_valid,
  input  logic irq_req,
  output logic push,
  output logic pop,
  output logic unpush,
  output logic alloc_ready,
  output logic restore_en,
  output logic flush_req,
  output logic rollback,
  output logic rollback_done
);

  hb_state_e state_q, state_d;
  logic      pend_q, pend_d;
  logic      state_en;
  logic      clean_head, bad_head;

  assign clean_head = !empty && head_done && !head_exc;
  assign bad_head   = !empty && head_done && head_exc;

  always_comb begin
    state_d       = state_q;
    pend_d        = pend_q | irq_req;
    push          = 1'b0;
    pop           = 1'b0;
    unpush        = 1'b0;
    alloc_ready   = 1'b0;
    restore_en    = 1'b0;
    flush_req     = 1'b0;
    rollback_done = 1'b0;
    unique case (state_q)
      HB_RUN: begin
        if (clean_head) begin
          pop = 1'b1;
        end else if (bad_head || pend_q || irq_req) begin
          flush_req = 1'b1;
          pend_d    = 1'b0;
          state_d   = HB_ROLLBACK;
        end
        alloc_ready = !full && !flush_req;
        push        = alloc_valid && alloc_ready;
      end
      HB_ROLLBACK: begin
        pend_d = 1'b0;
        if (empty) begin
          rollback_done = 1'b1;
          state_d       = HB_RUN;
        end else begin
          unpush     = 1'b1;
          restore_en = young_dvld;
        end
      end
      default: state_d = HB_RUN;
    endcase
  end

  assign state_en = (state_d != state_q) || (pend_d != pend_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HB_RUN;
      pend_q  <= 1'b0;
    end else if (state_en) begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  assign rollback = (state_q == HB_ROLLBACK);

endmodule

// File: rtl/hist_buf.sv
module hist_buf #(
  parameter int DEPTH  = 8,
  parameter int RIDX_W = 5,
  parameter int DATA_W = 32,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = TAG_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic              alloc_dest_vld,
  input  logic [RIDX_W-1:0] alloc_dest_idx,
  input  logic [DATA_W-1:0] alloc_old_val,
  output logic              alloc_ready,
  output logic [TAG_W-1:0]  alloc_tag,
  input  logic              cmpl_valid,
  input  logic [TAG_W-1:0]  cmpl_tag,
  input  logic              cmpl_exc,
  input  logic              irq_req,
  output logic              retire_valid,
  output logic [TAG_W-1:0]  retire_tag,
  output logic              rst_wr_en,
  output logic [RIDX_W-1:0] rst_wr_idx,
  output logic [DATA_W-1:0] rst_wr_data,
  output logic              iq_flush,
  output logic              recov_active,
  output logic              recov_done
);

  logic             push, pop, unpush;
  logic [TAG_W-1:0] head_ptr, tail_ptr, young_ptr;
  logic [CNT_W-1:0] occ_cnt;
  logic             full, empty;
  logic             head_done, head_exc, young_dvld;
  logic             cmpl_en;

  hb_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (push),
    .pop    (pop),
    .unpush (unpush),
    .head   (head_ptr),
    .tail   (tail_ptr),
    .young  (young_ptr),
    .count  (occ_cnt),
    .full   (full),
    .empty  (empty)
  );

  assign cmpl_en = cmpl_valid && !recov_active;

  hb_store #(.DEPTH(DEPTH), .RIDX_W(RIDX_W), .DATA_W(DATA_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (push),
    .wr_slot    (tail_ptr),
    .wr_dvld    (alloc_dest_vld),
    .wr_idx     (alloc_dest_idx),
    .wr_old     (alloc_old_val),
    .pop_en     (pop),
    .pop_slot   (head_ptr),
    .undo_en    (unpush),
    .undo_slot  (young_ptr),
    .cmpl_en    (cmpl_en),
    .cmpl_slot  (cmpl_tag),
    .cmpl_exc   (cmpl_exc),
    .head_slot  (head_ptr),
    .young_slot (young_ptr),
    .head_done  (head_done),
    .head_exc   (head_exc),
    .young_dvld (young_dvld),
    .young_idx  (rst_wr_idx),
    .young_old  (rst_wr_data)
  );

  hb_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .empty         (empty),
    .full          (full),
    .head_done     (head_done),
    .head_exc      (head_exc),
    .young_dvld    (young_dvld),
    .alloc_valid   (alloc_valid),
    .irq_req       (irq_req),
    .push          (push),
    .pop           (pop),
    .unpush        (unpush),
    .alloc_ready   (alloc_ready),
    .restore_en    (rst_wr_en),
    .flush_req     (iq_flush),
    .rollback      (recov_active),
    .rollback_done (recov_done)
  );

  assign alloc_tag    = tail_ptr;
  assign retire_valid = pop;
  assign retire_tag   = head_ptr;

endmodule

// File: rtl/hb_chk.sv
module hb_chk #(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_ready,
  input logic             retire_valid,
  input logic             iq_flush,
  input logic             recov_active,
  input logic             recov_done,
  input logic             rst_wr_en,
  input logic [CNT_W-1:0] occ_cnt
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_cnt == FULL_CNT) |-> !alloc_ready);

  // R5
  retire_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid |-> (!iq_flush && !recov_active));

  // R6
  flush_enters_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iq_flush |=> recov_active);

  // R6
  flush_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iq_flush |=> !iq_flush);

  // R7
  restore_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_wr_en |-> recov_active);

  // R7
  unwind_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (recov_active && !recov_done) |=> (occ_cnt == $past(occ_cnt) - 1'b1));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recov_done |=> (!recov_done && !recov_active && occ_cnt == '0));

  // R10
  alloc_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recov_active |-> !alloc_ready);

endmodule

bind hist_buf hb_chk #(.DEPTH(DEPTH)) u_hb_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .alloc_ready  (alloc_ready),
  .retire_valid (retire_valid),
  .iq_flush     (iq_flush),
  .recov_active (recov_active),
  .recov_done   (recov_done),
  .rst_wr_en    (rst_wr_en),
  .occ_cnt      (occ_cnt)
);

// File: tb/tb_hist_buf.sv
module tb_hist_buf;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        alloc_valid, alloc_dest_vld;
  logic [4:0]  alloc_dest_idx;
  logic [31:0] alloc_old_val;
  logic        alloc_ready;
  logic [2:0]  alloc_tag;
  logic        cmpl_valid, cmpl_exc, irq_req;
  logic [2:0]  cmpl_tag;
  logic        retire_valid;
  logic [2:0]  retire_tag;
  logic        rst_wr_en;
  logic [4:0]  rst_wr_idx;
  logic [31:0] rst_wr_data;
  logic        iq_flush, recov_active, recov_done;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 1'b0;

  always #5 clk = ~clk;

  hist_buf dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_dest_vld(alloc_dest_vld),
    .alloc_dest_idx(alloc_dest_idx), .alloc_old_val(alloc_old_val),
    .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag), .cmpl_exc(cmpl_exc),
    .irq_req(irq_req),
    .retire_valid(retire_valid), .retire_tag(retire_tag),
    .rst_wr_en(rst_wr_en), .rst_wr_idx(rst_wr_idx), .rst_wr_data(rst_wr_data),
    .iq_flush(iq_flush), .recov_active(recov_active), .recov_done(recov_done)
  );

  // {expected tag, dest valid, dest index, old value}
  localparam logic [40:0] FILL_TBL [8] = '{
    {3'd0, 1'b1, 5'd3,  32'h1000_0003},
    {3'd1, 1'b1, 5'd4,  32'h1111_0004},
    {3'd2, 1'b1, 5'd5,  32'h2222_0005},
    {3'd3, 1'b1, 5'd6,  32'h3333_0006},
    {3'd4, 1'b1, 5'd7,  32'h4444_0007},
    {3'd5, 1'b0, 5'd8,  32'h5555_0008},
    {3'd6, 1'b1, 5'd9,  32'h6666_0009},
    {3'd7, 1'b1, 5'd10, 32'h7777_000A}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic offer(input logic dv, input logic [4:0] idx, input logic [31:0] val);
    alloc_valid    = 1'b1;
    alloc_dest_vld = dv;
    alloc_dest_idx = idx;
    alloc_old_val  = val;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [40:0] row;
    alloc_valid = 0; alloc_dest_vld = 0; alloc_dest_idx = '0; alloc_old_val = '0;
    cmpl_valid = 0; cmpl_tag = '0; cmpl_exc = 0; irq_req = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 ready", alloc_ready, 1);
    chk("R1 tag", alloc_tag, 0);
    chk("R1 retire", retire_valid, 0);
    chk("R1 flush", iq_flush, 0);
    chk("R1 restore", rst_wr_en, 0);
    chk("R1 active", recov_active, 0);
    chk("R1 done", recov_done, 0);

    // R2 fill from table
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      row = FILL_TBL[i];
      offer(row[37], row[36:32], row[31:0]);
      #1;
      chk("R2 ready", alloc_ready, 1);
      chk("R2 tag", alloc_tag, row[40:38]);
    end
    // R3 full: offer is dropped
    @(negedge clk);
    offer(1'b1, 5'd31, 32'hDEAD_BEEF);
    #1;
    chk("R3 full stall", alloc_ready, 0);

    // R4 out-of-order completion, in-order retirement
    @(negedge clk);
    alloc_valid = 0;
    cmpl_valid = 1; cmpl_tag = 3'd2; cmpl_exc = 0;
    #1;
    chk("R4 no retire yet", retire_valid, 0);
    @(negedge clk);
    cmpl_tag = 3'd0;
    #1;
    chk("R4 younger done only", retire_valid, 0);
    @(negedge clk);
    cmpl_valid = 0;
    #1;
    chk("R4 retire head", retire_valid, 1);
    chk("R4 retire tag", retire_tag, 0);
    @(negedge clk);
    #1;
    chk("R5 head not done", retire_valid, 0);
    @(negedge clk);
    cmpl_valid = 1; cmpl_tag = 3'd1;
    @(negedge clk);
    cmpl_valid = 0;
    #1;
    chk("R5 retire 1", retire_valid, 1);
    chk("R5 retire tag 1", retire_tag, 1);
    @(negedge clk);
    #1;
    chk("R5 retire 2", retire_valid, 1);
    chk("R5 retire tag 2", retire_tag, 2);
    @(negedge clk);
    #1;
    chk("R5 stop at 3", retire_valid, 0);

    // R2 wrap to slot 0
    @(negedge clk);
    offer(1'b1, 5'd20, 32'hCAFE_0000);
    #1;
    chk("R2 wrap tag", alloc_tag, 0);
    chk("R2 wrap ready", alloc_ready, 1);

    // R6 exception on the oldest entry (tag 3)
    @(negedge clk);
    alloc_valid = 0;
    cmpl_valid = 1; cmpl_tag = 3'd3; cmpl_exc = 1;
    #1;
    chk("R6 no early flush", iq_flush, 0);
    @(negedge clk);
    cmpl_valid = 0; cmpl_exc = 0;
    offer(1'b1, 5'd30, 32'hBAD0_0001);
    #1;
    chk("R6 flush", iq_flush, 1);
    chk("R6 no retire", retire_valid, 0);
    chk("R6 alloc refused", alloc_ready, 0);

    // R7 youngest-first restore: slots 0,7,6,5,4,3
    for (int k = 0; k < 6; k++) begin
      int s;
      logic        e_dv;
      logic [4:0]  e_idx;
      logic [31:0] e_val;
      s = (k == 0) ? 0 : 8 - k;
      if (s == 0) begin
        e_dv = 1'b1; e_idx = 5'd20; e_val = 32'hCAFE_0000;
      end else begin
        e_dv = FILL_TBL[s][37]; e_idx = FILL_TBL[s][36:32]; e_val = FILL_TBL[s][31:0];
      end
      @(negedge clk);
      #1;
      chk("R7 active", recov_active, 1);
      chk("R10 alloc blocked", alloc_ready, 0);
      chk("R7 restore en", rst_wr_en, e_dv);
      if (e_dv) begin
        chk("R7 restore idx", rst_wr_idx, e_idx);
        chk("R7 restore data", rst_wr_data, e_val);
      end
    end
    @(negedge clk);
    #1;
    chk("R8 done pulse", recov_done, 1);
    chk("R8 no restore", rst_wr_en, 0);
    @(negedge clk);
    offer(1'b1, 5'd12, 32'h3000_0003);
    #1;
    chk("R8 done low", recov_done, 0);
    chk("R8 ready", alloc_ready, 1);
    chk("R8 R10 resume tag", alloc_tag, 3);
    @(negedge clk);
    offer(1'b1, 5'd13, 32'h4000_0004);
    #1;
    chk("R2 tag 4", alloc_tag, 4);
    @(negedge clk);
    offer(1'b1, 5'd14, 32'h5000_0005);
    #1;
    chk("R2 tag 5", alloc_tag, 5);

    // R9 interrupt: clean head retires first, then rollback
    @(negedge clk);
    alloc_valid = 0;
    cmpl_valid = 1; cmpl_tag = 3'd3; cmpl_exc = 0;
    @(negedge clk);
    cmpl_valid = 0;
    irq_req = 1;
    #1;
    chk("R9 retire first", retire_valid, 1);
    chk("R9 retire tag", retire_tag, 3);
    chk("R9 no flush yet", iq_flush, 0);
    @(negedge clk);
    irq_req = 0;
    #1;
    chk("R9 flush", iq_flush, 1);
    chk("R9 no retire", retire_valid, 0);
    @(negedge clk);
    #1;
    chk("R9 restore en 5", rst_wr_en, 1);
    chk("R9 restore idx 5", rst_wr_idx, 14);
    chk("R9 restore data 5", rst_wr_data, 32'h5000_0005);
    @(negedge clk);
    #1;
    chk("R9 restore idx 4", rst_wr_idx, 13);
    chk("R9 restore data 4", rst_wr_data, 32'h4000_0004);
    @(negedge clk);
    #1;
    chk("R9 done", recov_done, 1);
    @(negedge clk);
    #1;
    chk("R9 resume tag", alloc_tag, 4);
    chk("R9 active low", recov_active, 0);

    finish_run();
  end

endmodule